// File: doc/BRIEF.md
# External Data Space Window Decoder

This block sits between an 8-bit microcontroller core and its external-data-space accesses. For every MOVX-style read or write it decides where the access lands: in the on-chip XRAM, in the on-chip CAN register window, or on the external memory bus. It produces the select lines for the two internal targets and the strobes, address and data for the external bus. It also returns read data from whichever target served the access.

Accesses arrive either with a full 16-bit address from the data pointer or with an 8-bit address. In the 8-bit case a page register supplies the upper byte. The block holds this page register, the port-2 output latch that mirrors into it, and two control bits. The first is a window disable bit. Reset sets it and software can only clear it. The second is a visibility bit, which replays internal transfers on the external bus so they can be traced.

All decoding is combinational within the access cycle. A write to a control bit, the port-2 latch or the page register takes effect from the next clock edge.

Top module: `xdata_window`

## Requirements
- R1: After reset, the window disable bit is 1, the visibility bit is 0, the page register is 0x00 and the port-2 latch is 0xFF; with no access, every select, strobe and bus output is 0.
- R2: With the window enabled, an access whose effective address lies in 0xF800..0xFFFF asserts `xram_sel_o` and presents that address on `int_addr_o`.
- R3: With the window enabled, an access whose effective address lies in 0xF700..0xF7FF asserts `can_sel_o` and presents that address on `int_addr_o`.
- R4: An access whose effective address is below 0xF700 asserts `ext_cyc_o`, drives the bus address on `ext_addr_o` and asserts `ext_rd_o` for a read or `ext_wr_o` for a write (with `ext_wdata_o` = write data).
- R5: While the window disable bit is 1, every access, including those in 0xF700..0xFFFF, is an external cycle.
- R6: A control write with `ctl_off_i`=0 clears the window disable bit. A control write with `ctl_off_i`=1 leaves it unchanged. Only reset sets it again.
- R7: When `acc_short_i`=1, the effective address is {page register, `acc_lo_i`}. On the external bus, the high address byte is the port-2 latch.
- R8: A port-2 write loads `p2_wdata_i` into both the port-2 latch and the page register. A page write loads the page register alone. If both happen in one cycle, the page write's value wins for the page register.
- R9: Exactly one of `xram_sel_o`, `can_sel_o`, `ext_cyc_o` is 1 during an access, and none is 1 without one.
- R10: With the visibility bit 0, an internal access leaves `ext_drive_o`, `ext_rd_o`, `ext_wr_o`, `ext_addr_o` and `ext_wdata_o` at 0.
- R11: With the visibility bit 1, an internal access asserts `ext_drive_o` and the read or write strobe, and drives the bus address and, for writes, the write data.
- R12: The visibility bit does not change an access below 0xF700 or any access while the window is disabled.
- R13: `rdata_o` returns `xram_rdata_i`, `can_rdata_i` or `ext_rdata_i` according to the selected target, and 0 with no access.
- R14: A control, port-2 or page write in the same cycle as an access does not affect that access; the access uses the values held before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_req_i | input | 1 | Access valid this cycle |
| acc_we_i | input | 1 | 1 = write, 0 = read |
| acc_short_i | input | 1 | 1 = 8-bit address form using the page register |
| acc_addr_i | input | 16 | 16-bit address from the data pointer |
| acc_lo_i | input | 8 | Low address byte for the 8-bit form |
| acc_wdata_i | input | 8 | Write data |
| ctl_we_i | input | 1 | Control-bit write strobe |
| ctl_off_i | input | 1 | Window disable value (0 clears, 1 ignored) |
| ctl_show_i | input | 1 | Visibility bit value |
| p2_we_i | input | 1 | Port-2 latch write strobe |
| p2_wdata_i | input | 8 | Port-2 latch write value |
| page_we_i | input | 1 | Page register write strobe |
| page_wdata_i | input | 8 | Page register write value |
| xram_rdata_i | input | 8 | Read data from XRAM |
| can_rdata_i | input | 8 | Read data from CAN window |
| ext_rdata_i | input | 8 | Read data from external bus |
| xram_sel_o | output | 1 | XRAM select |
| can_sel_o | output | 1 | CAN window select |
| ext_cyc_o | output | 1 | External bus cycle enable |
| int_addr_o | output | 16 | Effective address to internal targets |
| int_we_o | output | 1 | Write enable to internal targets |
| int_wdata_o | output | 8 | Write data to internal targets |
| ext_drive_o | output | 1 | Ports 0 and 2 carry address/data |
| ext_rd_o | output | 1 | External read strobe |
| ext_wr_o | output | 1 | External write strobe |
| ext_addr_o | output | 16 | External bus address |
| ext_wdata_o | output | 8 | External bus write data |
| rdata_o | output | 8 | Read data to the core |

## Verification
Two functions can meet in one clock cycle. The first is the update of the registered state: the disable and visibility bits, the port-2 latch and the page register. The second is the combinational decode of an access that depends on that state. The bench provokes this by issuing an access in the same cycle as a control write that clears the disable bit. It also issues an 8-bit access together with a port-2 write that would move the page. In both cases the scoreboard computes the expected routing from the values held before the edge. An immediate access in the next cycle then confirms that the new value took hold.

// File: rtl/xdw_pkg.sv
package xdw_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_XRAM = 2'd1,
    TGT_CAN  = 2'd2,
    TGT_EXT  = 2'd3
  } tgt_e;
endpackage

// File: rtl/xdw_cfg.sv
module xdw_cfg #(
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_we_i,
  input  logic          ctl_off_i,
  input  logic          ctl_show_i,
  input  logic          p2_we_i,
  input  logic [PW-1:0] p2_wdata_i,
  input  logic          page_we_i,
  input  logic [PW-1:0] page_wdata_i,
  output logic          win_off_o,
  output logic          show_o,
  output logic [PW-1:0] page_o,
  output logic [PW-1:0] p2_o
);
  logic          off_q, show_q;
  logic [PW-1:0] page_q, p2_q, page_d;

  // disable bit: set by reset only, software may only clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q  <= 1'b1;
      show_q <= 1'b0;
    end else if (ctl_we_i) begin
      off_q  <= off_q & ctl_off_i;
      show_q <= ctl_show_i;
    end
  end

  always_comb begin
    page_d = page_q;
    if (p2_we_i)   page_d = p2_wdata_i;
    if (page_we_i) page_d = page_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      p2_q   <= '1;
    end else begin
      page_q <= page_d;
      if (p2_we_i) p2_q <= p2_wdata_i;
    end
  end

  assign win_off_o = off_q;
  assign show_o    = show_q;
  assign page_o    = page_q;
  assign p2_o      = p2_q;
endmodule

// File: rtl/xdw_decode.sv
module xdw_decode
  import xdw_pkg::*;
#(
  parameter int          AW      = 16,
  parameter int          LW      = 8,
  parameter logic [AW-1:0] XRAM_LO = 16'hF800,
  parameter logic [AW-1:0] XRAM_HI = 16'hFFFF,
  parameter logic [AW-1:0] CAN_LO  = 16'hF700,
  parameter logic [AW-1:0] CAN_HI  = 16'hF7FF,
  localparam int         PW      = AW - LW
) (
  input  logic          req_i,
  input  logic          short_i,
  input  logic [AW-1:0] addr_i,
  input  logic [LW-1:0] lo_i,
  input  logic [PW-1:0] page_i,
  input  logic [PW-1:0] p2_i,
  input  logic          win_off_i,
  output tgt_e          tgt_o,
  output logic [AW-1:0] eff_addr_o,
  output logic [AW-1:0] bus_addr_o
);
  logic in_xram, in_can;

  always_comb begin
    if (short_i) begin
      eff_addr_o = {page_i, lo_i};
      bus_addr_o = {p2_i, lo_i};
    end else begin
      eff_addr_o = addr_i;
      bus_addr_o = addr_i;
    end
  end

  assign in_xram = (eff_addr_o >= XRAM_LO) && (eff_addr_o <= XRAM_HI);
  assign in_can  = (eff_addr_o >= CAN_LO)  && (eff_addr_o <= CAN_HI);

  always_comb begin
    tgt_o = TGT_NONE;
    if (req_i) begin
      if (win_off_i)    tgt_o = TGT_EXT;
      else if (in_xram) tgt_o = TGT_XRAM;
      else if (in_can)  tgt_o = TGT_CAN;
      else              tgt_o = TGT_EXT;
    end
  end
endmodule

// File: rtl/xdw_steer.sv
module xdw_steer
  import xdw_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  tgt_e          tgt_i,
  input  logic          we_i,
  input  logic          show_i,
  input  logic [AW-1:0] eff_addr_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] xram_rdata_i,
  input  logic [DW-1:0] can_rdata_i,
  input  logic [DW-1:0] ext_rdata_i,
  output logic          xram_sel_o,
  output logic          can_sel_o,
  output logic          ext_cyc_o,
  output logic [AW-1:0] int_addr_o,
  output logic          int_we_o,
  output logic [DW-1:0] int_wdata_o,
  output logic          ext_drive_o,
  output logic          ext_rd_o,
  output logic          ext_wr_o,
  output logic [AW-1:0] ext_addr_o,
  output logic [DW-1:0] ext_wdata_o,
  output logic [DW-1:0] rdata_o
);
  logic internal;

  assign xram_sel_o = (tgt_i == TGT_XRAM);
  assign can_sel_o  = (tgt_i == TGT_CAN);
  assign ext_cyc_o  = (tgt_i == TGT_EXT);
  assign internal   = xram_sel_o | can_sel_o;

  assign int_addr_o  = internal ? eff_addr_i : '0;
  assign int_we_o    = internal & we_i;
  assign int_wdata_o = (internal & we_i) ? wdata_i : '0;

  // visible mode replays internal transfers on the external pins
  assign ext_drive_o = ext_cyc_o | (internal & show_i);
  assign ext_rd_o    = ext_drive_o & ~we_i;
  assign ext_wr_o    = ext_drive_o & we_i;
  assign ext_addr_o  = ext_drive_o ? bus_addr_i : '0;
  assign ext_wdata_o = ext_wr_o ? wdata_i : '0;

  always_comb begin
    unique case (tgt_i)
      TGT_XRAM: rdata_o = xram_rdata_i;
      TGT_CAN:  rdata_o = can_rdata_i;
      TGT_EXT:  rdata_o = ext_rdata_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/xdata_window.sv
module xdata_window
  import xdw_pkg::*;
#(
  parameter int            AW      = 16,
  parameter int            DW      = 8,
  parameter int            LW      = 8,
  parameter logic [AW-1:0] XRAM_LO = 16'hF800,
  parameter logic [AW-1:0] XRAM_HI = 16'hFFFF,
  parameter logic [AW-1:0] CAN_LO  = 16'hF700,
  parameter logic [AW-1:0] CAN_HI  = 16'hF7FF,
  localparam int           PW      = AW - LW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_req_i,
  input  logic          acc_we_i,
  input  logic          acc_short_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic [LW-1:0] acc_lo_i,
  input  logic [DW-1:0] acc_wdata_i,
  input  logic          ctl_we_i,
  input  logic          ctl_off_i,
  input  logic          ctl_show_i,
  input  logic          p2_we_i,
  input  logic [PW-1:0] p2_wdata_i,
  input  logic          page_we_i,
  input  logic [PW-1:0] page_wdata_i,
  input  logic [DW-1:0] xram_rdata_i,
  input  logic [DW-1:0] can_rdata_i,
  input  logic [DW-1:0] ext_rdata_i,
  output logic          xram_sel_o,
  output logic          can_sel_o,
  output logic          ext_cyc_o,
  output logic [AW-1:0] int_addr_o,
  output logic          int_we_o,
  output logic [DW-1:0] int_wdata_o,
  output logic          ext_drive_o,
  output logic          ext_rd_o,
  output logic          ext_wr_o,
  output logic [AW-1:0] ext_addr_o,
  output logic [DW-1:0] ext_wdata_o,
  output logic [DW-1:0] rdata_o
);
  logic          win_off, show;
  logic [PW-1:0] page, p2;
  logic [AW-1:0] eff_addr, bus_addr;
  tgt_e          tgt;

  xdw_cfg #(.PW(PW)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_we_i    (ctl_we_i),
    .ctl_off_i   (ctl_off_i),
    .ctl_show_i  (ctl_show_i),
    .p2_we_i     (p2_we_i),
    .p2_wdata_i  (p2_wdata_i),
    .page_we_i   (page_we_i),
    .page_wdata_i(page_wdata_i),
    .win_off_o   (win_off),
    .show_o      (show),
    .page_o      (page),
    .p2_o        (p2)
  );

  xdw_decode #(
    .AW(AW), .LW(LW),
    .XRAM_LO(XRAM_LO), .XRAM_HI(XRAM_HI),
    .CAN_LO(CAN_LO), .CAN_HI(CAN_HI)
  ) u_dec (
    .req_i     (acc_req_i),
    .short_i   (acc_short_i),
    .addr_i    (acc_addr_i),
    .lo_i      (acc_lo_i),
    .page_i    (page),
    .p2_i      (p2),
    .win_off_i (win_off),
    .tgt_o     (tgt),
    .eff_addr_o(eff_addr),
    .bus_addr_o(bus_addr)
  );

  xdw_steer #(.AW(AW), .DW(DW)) u_steer (
    .tgt_i       (tgt),
    .we_i        (acc_we_i),
    .show_i      (show),
    .eff_addr_i  (eff_addr),
    .bus_addr_i  (bus_addr),
    .wdata_i     (acc_wdata_i),
    .xram_rdata_i(xram_rdata_i),
    .can_rdata_i (can_rdata_i),
    .ext_rdata_i (ext_rdata_i),
    .xram_sel_o  (xram_sel_o),
    .can_sel_o   (can_sel_o),
    .ext_cyc_o   (ext_cyc_o),
    .int_addr_o  (int_addr_o),
    .int_we_o    (int_we_o),
    .int_wdata_o (int_wdata_o),
    .ext_drive_o (ext_drive_o),
    .ext_rd_o    (ext_rd_o),
    .ext_wr_o    (ext_wr_o),
    .ext_addr_o  (ext_addr_o),
    .ext_wdata_o (ext_wdata_o),
    .rdata_o     (rdata_o)
  );
endmodule

// File: rtl/xdata_window_chk.sv
module xdata_window_chk #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int PW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          acc_req_i,
  input logic          acc_we_i,
  input logic          acc_short_i,
  input logic [AW-1:0] acc_addr_i,
  input logic          p2_we_i,
  input logic [PW-1:0] p2_wdata_i,
  input logic          page_we_i,
  input logic [DW-1:0] ext_rdata_i,
  input logic          xram_sel_o,
  input logic          can_sel_o,
  input logic          ext_cyc_o,
  input logic          ext_drive_o,
  input logic          ext_rd_o,
  input logic          ext_wr_o,
  input logic [DW-1:0] rdata_o,
  input logic          win_off,
  input logic          show,
  input logic [PW-1:0] page
);
  assert_one_target_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_req_i |-> $onehot({xram_sel_o, can_sel_o, ext_cyc_o}));

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_req_i |-> !(xram_sel_o | can_sel_o | ext_cyc_o));

  assert_off_never_rises_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(win_off));

  assert_off_all_external_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_req_i && win_off) |-> ext_cyc_o);

  assert_xram_hit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_req_i && !win_off && !acc_short_i && acc_addr_i >= 16'hF800) |-> xram_sel_o);

  assert_page_mirror_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p2_we_i && !page_we_i) |=> page == $past(p2_wdata_i));

  assert_hidden_internal_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((xram_sel_o || can_sel_o) && !show) |-> !(ext_rd_o || ext_wr_o || ext_drive_o));

  assert_shown_internal_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((xram_sel_o || can_sel_o) && show) |-> (ext_rd_o != ext_wr_o));

  assert_ext_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_cyc_o |-> (acc_we_i ? ext_wr_o : ext_rd_o));

  assert_ext_rdata_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_cyc_o && !acc_we_i) |-> rdata_o == ext_rdata_i);
endmodule

bind xdata_window xdata_window_chk #(.AW(AW), .DW(DW), .PW(PW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .acc_req_i  (acc_req_i),
  .acc_we_i   (acc_we_i),
  .acc_short_i(acc_short_i),
  .acc_addr_i (acc_addr_i),
  .p2_we_i    (p2_we_i),
  .p2_wdata_i (p2_wdata_i),
  .page_we_i  (page_we_i),
  .ext_rdata_i(ext_rdata_i),
  .xram_sel_o (xram_sel_o),
  .can_sel_o  (can_sel_o),
  .ext_cyc_o  (ext_cyc_o),
  .ext_drive_o(ext_drive_o),
  .ext_rd_o   (ext_rd_o),
  .ext_wr_o   (ext_wr_o),
  .rdata_o    (rdata_o),
  .win_off    (win_off),
  .show       (show),
  .page       (page)
);

// File: tb/xdata_window_bench.sv
module xdata_window_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acc_req_i = 1'b0, acc_we_i = 1'b0, acc_short_i = 1'b0;
  logic [15:0] acc_addr_i = '0;
  logic [7:0]  acc_lo_i = '0, acc_wdata_i = '0;
  logic        ctl_we_i = 1'b0, ctl_off_i = 1'b0, ctl_show_i = 1'b0;
  logic        p2_we_i = 1'b0, page_we_i = 1'b0;
  logic [7:0]  p2_wdata_i = '0, page_wdata_i = '0;
  logic [7:0]  xram_rdata_i = 8'hA5, can_rdata_i = 8'h3C, ext_rdata_i = 8'h96;
  logic        xram_sel_o, can_sel_o, ext_cyc_o, int_we_o;
  logic        ext_drive_o, ext_rd_o, ext_wr_o;
  logic [15:0] int_addr_o, ext_addr_o;
  logic [7:0]  int_wdata_o, ext_wdata_o, rdata_o;

  always #4 clk_i = ~clk_i;

  xdata_window u_xdata_window (.*);

  typedef struct {
    string       tag;
    logic [2:0]  sel;
    logic [2:0]  bus;
    logic [15:0] eaddr;
    logic [7:0]  edata;
    logic [15:0] iaddr;
    logic [7:0]  rdata;
  } exp_t;

  exp_t q[$];
  int   tests = 0, fails = 0;
  bit   done = 1'b0;

  // reference state
  bit       m_off, m_show;
  bit [7:0] m_page, m_p2;

  task automatic model_reset();
    m_off = 1'b1; m_show = 1'b0; m_page = 8'h00; m_p2 = 8'hFF;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    acc_req_i = 0; ctl_we_i = 0; p2_we_i = 0; page_we_i = 0;
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    model_reset();
  endtask

  task automatic step(input bit req, input bit we, input bit short_a,
                      input bit [15:0] a16, input bit [7:0] a8, input bit [7:0] wd,
                      input bit cwe, input bit coff, input bit cshow,
                      input bit pwe, input bit [7:0] pd,
                      input bit gwe, input bit [7:0] gd, input string tag);
    exp_t e;
    bit [15:0] eff, busa;
    bit x, c, ex, drv;
    @(negedge clk_i);
    acc_req_i = req; acc_we_i = we; acc_short_i = short_a;
    acc_addr_i = a16; acc_lo_i = a8; acc_wdata_i = wd;
    ctl_we_i = cwe; ctl_off_i = coff; ctl_show_i = cshow;
    p2_we_i = pwe; p2_wdata_i = pd; page_we_i = gwe; page_wdata_i = gd;
    eff  = short_a ? {m_page, a8} : a16;
    busa = short_a ? {m_p2, a8} : a16;
    x   = req && !m_off && eff >= 16'hF800;
    c   = req && !m_off && eff[15:8] == 8'hF7;
    ex  = req && !(x || c);
    drv = ex || ((x || c) && m_show);
    e.tag   = tag;
    e.sel   = {x, c, ex};
    e.bus   = {drv, drv && !we, drv && we};
    e.eaddr = drv ? busa : 16'h0;
    e.edata = (drv && we) ? wd : 8'h0;
    e.iaddr = (x || c) ? eff : 16'h0;
    e.rdata = x ? xram_rdata_i : c ? can_rdata_i : ex ? ext_rdata_i : 8'h0;
    q.push_back(e);
    if (cwe) begin m_off = m_off & coff; m_show = cshow; end
    if (pwe) begin m_p2 = pd; m_page = pd; end
    if (gwe) m_page = gd;
  endtask

  task automatic rd16(input bit [15:0] a, input string tag);
    step(1, 0, 0, a, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic wr16(input bit [15:0] a, input bit [7:0] d, input string tag);
    step(1, 1, 0, a, 0, d, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic rd8(input bit [7:0] a, input string tag);
    step(1, 0, 1, 0, a, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  // monitor: pops one expected item per cycle, mid low phase
  initial begin
    forever begin
      @(negedge clk_i);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        logic [2:0] s, b;
        e = q.pop_front();
        s = {xram_sel_o, can_sel_o, ext_cyc_o};
        b = {ext_drive_o, ext_rd_o, ext_wr_o};
        tests++;
        if (s !== e.sel || b !== e.bus || ext_addr_o !== e.eaddr ||
            ext_wdata_o !== e.edata || int_addr_o !== e.iaddr || rdata_o !== e.rdata) begin
          fails++;
          $display("FAIL %s: act sel=%b bus=%b ea=%h ed=%h ia=%h rd=%h exp sel=%b bus=%b ea=%h ed=%h ia=%h rd=%h",
                   e.tag, s, b, ext_addr_o, ext_wdata_o, int_addr_o, rdata_o,
                   e.sel, e.bus, e.eaddr, e.edata, e.iaddr, e.rdata);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 idle after reset");
    rd16(16'hF900, "R5 xram range while disabled");
    wr16(16'hF710, 8'h11, "R5 can range while disabled");
    rd8(8'h10, "R7 short form uses page 00, bus high byte FF (R1)");
    // clear disable in the same cycle as an access
    step(1, 0, 0, 16'hF800, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R14 access beside clear uses old state");
    rd16(16'hF800, "R2 xram low edge, hidden (R10)");
    wr16(16'hFFFF, 8'h77, "R2 xram high edge write");
    rd16(16'hF700, "R3 can low edge");
    wr16(16'hF7FF, 8'h44, "R3 can high edge write");
    rd16(16'hF6FF, "R4 just below window, R13 ext rdata");
    wr16(16'h0000, 8'hC3, "R4 external write");
    step(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, "R6 write of 1 to disable");
    rd16(16'hF800, "R6 disable stays clear");
    step(0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 0, 0, 0, "R11 set visibility");
    rd16(16'hF880, "R11 visible xram read");
    wr16(16'hF7AA, 8'h5A, "R11 visible can write");
    rd16(16'hF000, "R12 visibility on, below window");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'hF8, 0, 0, "R8 port-2 write");
    rd8(8'h22, "R8 mirrored page selects xram");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'hF7, "R8 page-only write");
    step(1, 1, 1, 0, 8'h01, 8'h9E, 0, 0, 0, 0, 0, 0, 0, "R7 page F7 can, bus high byte F8");
    step(1, 0, 1, 0, 8'h05, 0, 0, 0, 0, 1, 8'h12, 0, 0, "R14 short access beside port-2 write");
    rd8(8'h06, "R14 new page 12 now external");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h40, 1, 8'hF9, "R8 both writes same cycle");
    rd8(8'h00, "R8 page write wins, bus uses port-2");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 idle no select");
    do_reset();
    rd16(16'hF800, "R6 reset sets disable again (R1)");
    step(0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0, "R12 visibility on while disabled");
    rd16(16'hFA00, "R12 disabled window stays external");
    wr16(16'hF7C0, 8'h21, "R12 disabled can range write");
    @(negedge clk_i);
    acc_req_i = 0; ctl_we_i = 0; p2_we_i = 0; page_we_i = 0;
    repeat (3) @(negedge clk_i);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule